// File: doc/BRIEF.md
# SPI Pad Direction and Idle-Level Controller

This block sits between a small 8-bit serial shift engine and the four pads of a serial peripheral link: serial clock, select, controller-out data (MOSI) and controller-in data (MISO). One configuration input picks the role, master or slave. From that bit alone the block decides which pads it drives and which it only reads. Every pad has its own value output and enable output, so a pad ring can build the tri-state buffers and a bench can see the high-impedance state.

In master mode the select pad is active-low and is framed around each byte. Between frames the MOSI pad takes a level chosen by two configuration inputs. It either keeps the last data bit that was shifted out or is forced to a constant 0 or 1. In slave mode MISO is driven only while the module is enabled and the select pad is low. The slave shifts its byte out on trailing clock edges and collects a byte from MOSI.

Bytes enter on a valid/ready stream. A byte is accepted in the cycle where `tx_valid` and `tx_ready` are both high. Holding `tx_valid` high while `tx_ready` is low is allowed, and the byte waits. Received bytes leave on `rx_valid`/`rx_data`. This output has no back-pressure: `rx_valid` is a one-cycle pulse, and `rx_data` keeps its value until the next byte completes.

Top module: `spi_pad_ctrl`

## Requirements
- R1: With `master`=1, `sclk_oe`, `ss_oe` and `mosi_oe` are 1 and `miso_oe` is 0.
- R2: With `master`=0, `sclk_oe`, `ss_oe` and `mosi_oe` are 0.
- R3: With `master`=0, `miso_oe` is 1 exactly when `en`=1 and `ss_i`=0; otherwise MISO is high-impedance.
- R4: In master mode with `idle_fix_en`=0, MOSI keeps the last shifted-out bit while select is high and does not change until the next frame. With `cpha`=1 that bit is bit 0 of the previous byte. With `cpha`=0 the idle value is not specified.
- R5: In master mode with `idle_fix_en`=1, MOSI equals `idle_fix_val` whenever select is high.
- R6: `ss_o` is active-low. It falls on the accepting clock edge, HALF_DIV cycles before the first serial clock edge. It rises HALF_DIV cycles after the last serial clock edge.
- R7: A master frame has 16 serial clock edges, each HALF_DIV cycles apart, sending the byte MSB first. `sclk_o` rests at `cpol` outside frames. The byte sampled from MISO appears on `rx_data`.
- R8: With `cpha`=0, bit 7 is on MOSI from the moment select falls. With `cpha`=1, MOSI keeps its previous value until the first clock edge.
- R9: `tx_ready` is high only when `en`=1 and the block is free: in master mode, an idle engine; in slave mode, `ss_i`=1. In master mode `rx_valid` pulses for one cycle, on the edge where select rises.
- R10: After reset, `ss_o`=1, `sclk_o`=`cpol`, `rx_valid`=0, and the held MOSI bit is 0.
- R11: In slave mode, MISO presents bit 7 of the loaded byte and advances one bit per trailing `sclk_i` edge. MOSI is sampled on the data edge selected by `cpha`, and after 8 bits `rx_valid` pulses with the byte.
- R12: After a master frame, select stays high and `tx_ready` stays low for HALF_DIV cycles before the next byte can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Module enable |
| master | input | 1 | 1 = master role, 0 = slave role |
| cpol | input | 1 | Serial clock rest level |
| cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| idle_fix_en | input | 1 | Force MOSI to a constant between frames |
| idle_fix_val | input | 1 | Constant used when forcing |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Byte can be accepted |
| tx_data | input | 8 | Byte to send |
| rx_valid | output | 1 | One-cycle pulse: byte received |
| rx_data | output | 8 | Last received byte |
| sclk_i | input | 1 | Serial clock pad input |
| sclk_o | output | 1 | Serial clock pad value |
| sclk_oe | output | 1 | Serial clock pad enable |
| ss_i | input | 1 | Select pad input |
| ss_o | output | 1 | Select pad value |
| ss_oe | output | 1 | Select pad enable |
| mosi_i | input | 1 | MOSI pad input |
| mosi_o | output | 1 | MOSI pad value |
| mosi_oe | output | 1 | MOSI pad enable |
| miso_i | input | 1 | MISO pad input |
| miso_o | output | 1 | MISO pad value |
| miso_oe | output | 1 | MISO pad enable |

## Verification
The pad enables and the idle MOSI level are combinational from the role bit, `en` and `ss_i`. The bench checks them one time step after changing an input, away from the clock edge. Master results are timed by counting falling-clock samples: select falls on the accepting edge, the first serial clock edge comes HALF_DIV cycles later, and each further edge comes HALF_DIV cycles after the one before. `rx_valid`, `rx_data` and the idle MOSI level are read at the sample just after select rises, and the select-high gap is measured until `tx_ready` returns. Slave results pass through the two-stage clock synchronizer plus one register. The bench therefore waits five cycles after every `sclk_i` change before reading MISO, and it catches the `rx_valid` pulse with a falling-edge monitor.

// File: rtl/spi_pad_pkg.sv
package spi_pad_pkg;
  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_LEAD = 2'd1,
    M_XFER = 2'd2,
    M_GAP  = 2'd3
  } mst_state_e;
endpackage

// File: rtl/spi_master_engine.sv
module spi_master_engine
  import spi_pad_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpha,
  input  logic              start,
  input  logic [DATA_W-1:0] start_data,
  input  logic              miso_s,
  output logic              ready_o,
  output logic              sel_o,
  output logic              tog_o,
  output logic              bit_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int EDGES  = 2 * DATA_W;
  localparam int ECW    = $clog2(EDGES);
  localparam int HCW    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [HCW-1:0] HC_MAX = HCW'(HALF_DIV - 1);
  localparam logic [ECW-1:0] E_LAST = ECW'(EDGES - 1);
  localparam int MSB = DATA_W - 1;

  mst_state_e        st;
  logic [HCW-1:0]    hcnt;
  logic [ECW-1:0]    ecnt;
  logic [DATA_W-1:0] sh, rx, rx_out;
  logic              tog, cur, done;

  // edge scheduling: which clock edge fires now and what it does
  logic [ECW-1:0] edge_idx;
  logic           fire, is_lead, do_shift, do_samp;

  always_comb begin
    edge_idx = (st == M_LEAD) ? '0 : ecnt + ECW'(1);
    fire     = (hcnt == '0) &&
               ((st == M_LEAD) || ((st == M_XFER) && (ecnt != E_LAST)));
    is_lead  = ~edge_idx[0];
    do_shift = cpha ? is_lead : (!is_lead && (edge_idx != E_LAST));
    do_samp  = cpha ? !is_lead : is_lead;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= M_IDLE;
      hcnt   <= '0;
      ecnt   <= '0;
      sh     <= '0;
      rx     <= '0;
      rx_out <= '0;
      tog    <= 1'b0;
      cur    <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        M_IDLE: begin
          if (start) begin
            st   <= M_LEAD;
            hcnt <= HC_MAX;
            tog  <= 1'b0;
            if (!cpha) begin
              cur <= start_data[MSB];
              sh  <= {start_data[MSB-1:0], 1'b0};
            end else begin
              sh  <= start_data;
            end
          end
        end
        M_LEAD: begin
          if (hcnt != '0) hcnt <= hcnt - HCW'(1);
          else begin
            st   <= M_XFER;
            hcnt <= HC_MAX;
            ecnt <= '0;
          end
        end
        M_XFER: begin
          if (hcnt != '0) hcnt <= hcnt - HCW'(1);
          else if (ecnt == E_LAST) begin
            st     <= M_GAP;
            hcnt   <= HC_MAX;
            done   <= 1'b1;
            rx_out <= rx;
          end else begin
            ecnt <= ecnt + ECW'(1);
            hcnt <= HC_MAX;
          end
        end
        default: begin
          if (hcnt != '0) hcnt <= hcnt - HCW'(1);
          else st <= M_IDLE;
        end
      endcase

      if (fire) begin
        tog <= ~tog;
        if (do_shift) begin
          cur <= sh[MSB];
          sh  <= {sh[MSB-1:0], 1'b0};
        end
        if (do_samp) rx <= {rx[MSB-1:0], miso_s};
      end
    end
  end

  assign ready_o = (st == M_IDLE);
  assign sel_o   = (st == M_LEAD) || (st == M_XFER);
  assign tog_o   = tog;
  assign bit_o   = cur;
  assign done_o  = done;
  assign rx_o    = rx_out;
endmodule

// File: rtl/spi_slave_engine.sv
module spi_slave_engine #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              active,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sclk_i,
  input  logic              mosi_i,
  output logic              miso_bit,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int MSB = DATA_W - 1;
  localparam int CW  = $clog2(DATA_W);
  localparam logic [CW-1:0] C_LAST = CW'(DATA_W - 1);

  logic [SYNC_STAGES:0] sy;
  logic [DATA_W-1:0]    sh, rx;
  logic [CW-1:0]        cnt;
  logic                 done;
  logic                 s_cur, s_prev, lead_e, trail_e, samp_e;

  always_comb begin
    s_cur   = sy[SYNC_STAGES-1];
    s_prev  = sy[SYNC_STAGES];
    lead_e  = (s_cur != cpol) && (s_prev == cpol);
    trail_e = (s_cur == cpol) && (s_prev != cpol);
    samp_e  = cpha ? trail_e : lead_e;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy   <= '0;
      sh   <= '0;
      rx   <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      sy   <= {sy[SYNC_STAGES-1:0], sclk_i};
      done <= 1'b0;
      if (load) sh <= load_data;
      else if (active && trail_e) sh <= {sh[MSB-1:0], 1'b0};
      if (!active) cnt <= '0;
      else if (samp_e) begin
        rx <= {rx[MSB-1:0], mosi_i};
        if (cnt == C_LAST) begin
          cnt  <= '0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign miso_bit = sh[MSB];
  assign done_o   = done;
  assign rx_o     = rx;
endmodule

// File: rtl/spi_pad_mux.sv
module spi_pad_mux (
  input  logic master,
  input  logic en,
  input  logic ss_i,
  input  logic cpol,
  input  logic sel,
  input  logic tog,
  input  logic cur_bit,
  input  logic fix_en,
  input  logic fix_val,
  input  logic slave_bit,
  output logic sclk_o,
  output logic sclk_oe,
  output logic ss_o,
  output logic ss_oe,
  output logic mosi_o,
  output logic mosi_oe,
  output logic miso_o,
  output logic miso_oe
);
  logic idle_bit;

  always_comb begin
    idle_bit = fix_en ? fix_val : cur_bit;
    sclk_o   = cpol ^ tog;
    ss_o     = ~sel;
    mosi_o   = sel ? cur_bit : idle_bit;
    miso_o   = slave_bit;
    sclk_oe  = master;
    ss_oe    = master;
    mosi_oe  = master;
    miso_oe  = !master && en && !ss_i;
  end
endmodule

// File: rtl/spi_pad_ctrl.sv
module spi_pad_ctrl #(
  parameter int DATA_W      = 8,
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              master,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              idle_fix_en,
  input  logic              idle_fix_val,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe,
  input  logic              ss_i,
  output logic              ss_o,
  output logic              ss_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe
);
  logic              m_ready, m_sel, m_tog, m_bit, m_done;
  logic [DATA_W-1:0] m_rx, s_rx;
  logic              s_bit, s_done, s_active, accept;

  assign tx_ready = en && (master ? m_ready : ss_i);
  assign accept   = tx_valid && tx_ready;
  assign s_active = !master && en && !ss_i;
  assign rx_valid = m_done || s_done;
  assign rx_data  = master ? m_rx : s_rx;

  spi_master_engine #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) u_mst (
    .clk(clk), .rst_n(rst_n), .cpha(cpha),
    .start(accept && master), .start_data(tx_data), .miso_s(miso_i),
    .ready_o(m_ready), .sel_o(m_sel), .tog_o(m_tog), .bit_o(m_bit),
    .done_o(m_done), .rx_o(m_rx)
  );

  spi_slave_engine #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_slv (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .active(s_active),
    .load(accept && !master), .load_data(tx_data), .sclk_i(sclk_i),
    .mosi_i(mosi_i), .miso_bit(s_bit), .done_o(s_done), .rx_o(s_rx)
  );

  spi_pad_mux u_mux (
    .master(master), .en(en), .ss_i(ss_i), .cpol(cpol), .sel(m_sel),
    .tog(m_tog), .cur_bit(m_bit), .fix_en(idle_fix_en), .fix_val(idle_fix_val),
    .slave_bit(s_bit), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .ss_o(ss_o),
    .ss_oe(ss_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_o(miso_o),
    .miso_oe(miso_oe)
  );
endmodule

// File: rtl/spi_pad_ctrl_chk.sv
module spi_pad_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              master,
  input logic              cpol,
  input logic              idle_fix_en,
  input logic              idle_fix_val,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              ss_i,
  input logic              sclk_o,
  input logic              sclk_oe,
  input logic              ss_o,
  input logic              ss_oe,
  input logic              mosi_o,
  input logic              mosi_oe,
  input logic              miso_oe
);
  p_master_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
    master |-> (sclk_oe && ss_oe && mosi_oe && !miso_oe));

  p_slave_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> (!sclk_oe && !ss_oe && !mosi_oe));

  p_miso_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && (ss_i || !en)) |-> !miso_oe);

  p_miso_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && en && !ss_i) |-> miso_oe);

  p_hold_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (master && ss_o && !idle_fix_en && $past(rst_n) && $past(master) &&
     $past(ss_o) && !$past(idle_fix_en)) |-> $stable(mosi_o));

  p_idle_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (master && ss_o && idle_fix_en) |-> (mosi_o == idle_fix_val));

  p_no_edge_at_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (master && $fell(ss_o)) |-> (sclk_o == cpol));

  p_sclk_rest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (master && ss_o) |-> (sclk_o == cpol));

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (master && tx_ready) |-> ss_o);

  p_rx_at_negate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (master && rx_valid) |-> $rose(ss_o));

  // rx_data only matters alongside rx_valid; keep it known then
  p_rx_known_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !$isunknown(rx_data));
endmodule

bind spi_pad_ctrl spi_pad_ctrl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/spi_pad_ctrl_test.sv
module spi_pad_ctrl_test;
  localparam int HALF = 4;
  localparam int NV   = 8;
  // fields: [11]=cpol [10]=cpha [9]=idle_fix_en [8]=idle_fix_val [7:0]=byte
  localparam logic [11:0] VEC [NV] = '{
    12'h0A5, 12'h43C, 12'hCC3, 12'hB5A, 12'h2FF, 12'hA81, 12'h700, 12'hD7E
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, en, master, cpol, cpha, idle_fix_en, idle_fix_val;
  logic       tx_valid, tx_ready, rx_valid;
  logic [7:0] tx_data, rx_data;
  logic       sclk_i, sclk_o, sclk_oe, ss_i, ss_o, ss_oe;
  logic       mosi_i, mosi_o, mosi_oe, miso_i, miso_o, miso_oe, miso_drv;

  assign miso_i = master ? mosi_o : miso_drv;

  spi_pad_ctrl #(.DATA_W(8), .HALF_DIV(HALF), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .master(master), .cpol(cpol),
    .cpha(cpha), .idle_fix_en(idle_fix_en), .idle_fix_val(idle_fix_val),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .sclk_i(sclk_i),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .ss_i(ss_i), .ss_o(ss_o),
    .ss_oe(ss_oe), .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe)
  );

  int total = 0;
  int bad   = 0;
  int seen  = 0;
  logic [7:0] last_rx = '0;

  always @(negedge clk) if (rst_n && rx_valid) begin
    seen    = seen + 1;
    last_rx = rx_data;
  end

  task automatic eq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic master_xfer(input logic [7:0] d, input int exp_idle);
    int lead = 0, tail = 0, toggles = 0, gap = 0;
    logic last_s, pre_mosi;
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    pre_mosi = mosi_o;
    tx_valid = 1'b1;
    tx_data  = d;
    @(negedge clk);
    tx_valid = 1'b0;
    eq("R6 select low after accept", ss_o, 0);
    eq("R9 not ready in frame", tx_ready, 0);
    if (!cpha) eq("R8 first bit at select", mosi_o, d[7]);
    else if (!idle_fix_en) eq("R8 mosi kept before edge", mosi_o, pre_mosi);
    last_s = sclk_o;
    while (sclk_o == last_s && ss_o == 1'b0) begin
      lead++;
      @(negedge clk);
    end
    eq("R6 lead half period", lead, HALF);
    while (ss_o == 1'b0) begin
      if (sclk_o != last_s) begin
        toggles++;
        tail   = 0;
        last_s = sclk_o;
      end
      tail++;
      @(negedge clk);
    end
    eq("R7 clock edge count", toggles, 16);
    eq("R6 trail half period", tail, HALF);
    eq("R9 rx pulse at negate", rx_valid, 1);
    eq("R7 loopback byte", rx_data, d);
    eq("R7 clock rest level", sclk_o, cpol);
    if (exp_idle >= 0)
      eq(idle_fix_en ? "R5 fixed idle" : "R4 held idle", mosi_o, exp_idle);
    while (!tx_ready && gap < 100) begin
      gap++;
      @(negedge clk);
    end
    eq("R12 negate gap", gap, HALF);
    if (exp_idle >= 0) begin
      repeat (10) @(negedge clk);
      eq(idle_fix_en ? "R5 fixed idle later" : "R4 held idle later", mosi_o, exp_idle);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; en = 1; master = 1; cpol = 0; cpha = 0;
    idle_fix_en = 0; idle_fix_val = 0; tx_valid = 0; tx_data = '0;
    sclk_i = 0; ss_i = 1; mosi_i = 0; miso_drv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    eq("R10 select high", ss_o, 1);
    eq("R10 held bit zero", mosi_o, 0);
    eq("R10 no rx pulse", rx_valid, 0);
    eq("R10 clock rest", sclk_o, 0);
    eq("R9 ready when idle", tx_ready, 1);
    cpol = 1; #1;
    eq("R10 clock rest follows cpol", sclk_o, 1);
    eq("R1 master enables", {sclk_oe, ss_oe, mosi_oe, miso_oe}, 4'b1110);

    // table-driven master frames
    for (int i = 0; i < NV; i++) begin
      int ei;
      @(negedge clk);
      cpol = VEC[i][11]; cpha = VEC[i][10];
      idle_fix_en = VEC[i][9]; idle_fix_val = VEC[i][8];
      if (VEC[i][9]) ei = int'(VEC[i][8]);
      else if (VEC[i][10]) ei = int'(VEC[i][0]);
      else ei = -1;
      master_xfer(VEC[i][7:0], ei);
    end

    // disabled master ignores offered byte
    @(negedge clk);
    en = 0; tx_valid = 1; tx_data = 8'h99;
    #1 eq("R9 not ready when disabled", tx_ready, 0);
    begin
      int lows = 0;
      repeat (12) begin
        @(negedge clk);
        if (!ss_o) lows++;
      end
      eq("R9 no frame while disabled", lows, 0);
    end
    tx_valid = 0; en = 1;

    // slave role
    @(negedge clk);
    master = 0; cpol = 0; cpha = 0; ss_i = 1; seen = 0;
    #1;
    eq("R2 slave enables", {sclk_oe, ss_oe, mosi_oe}, 3'b000);
    eq("R3 hiz when deselected", miso_oe, 0);
    eq("R9 slave ready when deselected", tx_ready, 1);
    tx_valid = 1; tx_data = 8'hB4;
    @(negedge clk);
    tx_valid = 0;
    ss_i = 0; #1;
    eq("R3 driven when selected", miso_oe, 1);
    eq("R9 slave busy when selected", tx_ready, 0);
    en = 0; #1;
    eq("R3 hiz when disabled", miso_oe, 0);
    en = 1; #1;
    for (int k = 0; k < 8; k++) begin
      logic [7:0] sb, mb;
      sb = 8'hB4; mb = 8'h6D;
      mosi_i = mb[7-k];
      repeat (2) @(negedge clk);
      sclk_i = 1;
      repeat (5) @(negedge clk);
      eq("R11 slave miso bit", miso_o, sb[7-k]);
      sclk_i = 0;
      repeat (5) @(negedge clk);
    end
    eq("R11 slave rx pulses", seen, 1);
    eq("R11 slave rx byte", last_rx, 8'h6D);
    ss_i = 1; #1;
    eq("R3 hiz after deselect", miso_oe, 0);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule